// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block handles interrupt detection for one GPIO bank. The bank is built from several ports, and each port has eight pins. Every pin has its own trigger setting. A pin can fire on a high level, a low level, a rising edge, a falling edge, or on both edges. When a pin detects an event, the block sets that pin's bit in its port's status vector. The block then ANDs the status bits with the per-pin enable bits and ORs the results over every port. That OR drives a single bank interrupt line.

Software controls the block through one write channel. Each write picks a port and a target: the trigger register, the enable register or the clear action. Software clears a pending status bit by writing a one to that bit. Writing a zero to a bit leaves it alone. The pin inputs are expected to be synchronised already. The block compares each pin with its value one cycle earlier, so it never misses an edge that arrives after a clear. When a clear and a new event hit the same bit in the same cycle, the event wins.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is applied and in the first cycle after it, every status bit and every enable bit is 0 and `irq` is 0.
- R2: The write channel works as follows. A write with `wr_sel`=0 loads the trigger register of port `wr_port` from `wr_data[23:0]`. In that register, pin i uses bit i as polarity, bit 8+i as edge mode and bit 16+i as both-edges. A write with `wr_sel`=1 loads the enable bits from `wr_data[7:0]`. A write with `wr_sel`=2 is a clear with mask `wr_data[7:0]`. Trigger code 0x000001<<i (level high) sets status bit i in any cycle where pin i is high.
- R3: Trigger code 0 (level low) sets status bit i in any cycle where pin i is low.
- R4: Trigger code 0x000101<<i (rising edge) sets status bit i one clock after pin i goes from 0 to 1. A steady level does not set it, and neither does a 1-to-0 change.
- R5: Trigger code 0x000100<<i (falling edge) sets status bit i one clock after pin i goes from 1 to 0. A steady level does not set it, and neither does a 0-to-1 change.
- R6: Trigger code 0x010100<<i (both edges) sets status bit i after any change of pin i.
- R7: A set status bit stays set until a clear write has a one in that bit position. Clear bits that are zero leave status unchanged.
- R8: In level mode, a clear has no effect while the pin is still at its active level. After the level goes inactive, the status bit stays set until it is cleared.
- R9: If an edge event and a clear of the same bit fall in the same cycle, the bit ends up set. An edge that arrives after a clear sets the bit again.
- R10: `irq` is 1 exactly when some status bit and its enable bit are both 1, across all ports. Enables reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Synchronised pin levels; port p occupies bits 8p+7..8p |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 trigger, 1 enable, 2 clear |
| wr_port | input | 2 | Port addressed by the write |
| wr_data | input | 24 | Write data |
| rd_port | input | 2 | Port whose status is shown on `rd_status` |
| rd_status | output | 8 | Status vector of port `rd_port` |
| irq | output | 1 | Combined bank interrupt |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as a fresh edge on the same pin. Reaching it needs the pin change and the clear strobe to be driven on the same falling clock edge, so that a single rising edge samples both. The bench sets up that alignment for one pin in every port. It also sweeps every trigger mode over all 32 pins. In each sweep it applies active and inactive levels, edges of each direction, clears while the level is still active, and clear masks that are all zeros in the target bit. It checks status and `irq` with and without the enable bit set.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        WR_TRIG   = 2'd0,
        WR_ENABLE = 2'd1,
        WR_CLEAR  = 2'd2
    } wr_sel_e;

    typedef struct packed {
        logic both;
        logic edge_mode;
        logic pol;
    } trig_t;

    // Event for one pin given its trigger setting, level now and level one cycle earlier.
    function automatic logic pin_hit(trig_t t, logic cur, logic prev);
        logic rise, fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        if (t.edge_mode) begin
            if (t.both) pin_hit = rise | fall;
            else        pin_hit = t.pol ? rise : fall;
        end else begin
            pin_hit = ~(t.pol ^ cur);
        end
    endfunction

endpackage

// File: rtl/gpio_irq_pin_det.sv
module gpio_irq_pin_det
    import gpio_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin,
    input  trig_t trig,
    input  logic  clr,
    output logic  sta
);

    logic prev_q;
    logic sta_q;
    logic hit;

    assign hit = pin_hit(trig, pin, prev_q);

    always_ff @(posedge clk) begin
        prev_q <= pin;
        if (rst) begin
            sta_q <= 1'b0;
        end else begin
            // a new event takes priority over a clear in the same cycle
            sta_q <= hit | (sta_q & ~clr);
        end
    end

    assign sta = sta_q;

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter  int PINS = 8,
    localparam int TW   = 3 * PINS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pins,
    input  logic            trig_we,
    input  logic            enb_we,
    input  logic            clr_we,
    input  logic [TW-1:0]   wdata,
    output logic [PINS-1:0] sta,
    output logic [PINS-1:0] enb,
    output logic [PINS-1:0] pol,
    output logic [PINS-1:0] edg,
    output logic [PINS-1:0] both,
    output logic            pend
);

    logic [TW-1:0]   trig_q;
    logic [PINS-1:0] enb_q;
    logic [PINS-1:0] clr_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
            enb_q  <= '0;
        end else begin
            if (trig_we) trig_q <= wdata;
            if (enb_we)  enb_q  <= wdata[PINS-1:0];
        end
    end

    assign clr_vec = clr_we ? wdata[PINS-1:0] : '0;

    assign pol  = trig_q[PINS-1:0];
    assign edg  = trig_q[2*PINS-1:PINS];
    assign both = trig_q[3*PINS-1:2*PINS];

    for (genvar gi = 0; gi < PINS; gi++) begin : g_pin
        trig_t t;
        assign t = '{both: both[gi], edge_mode: edg[gi], pol: pol[gi]};
        gpio_irq_pin_det u_det (
            .clk  (clk),
            .rst  (rst),
            .pin  (pins[gi]),
            .trig (t),
            .clr  (clr_vec[gi]),
            .sta  (sta[gi])
        );
    end

    assign enb  = enb_q;
    assign pend = |(sta & enb_q);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter  int PORTS = 4,
    parameter  int PINS  = 8,
    localparam int PW    = (PORTS > 1) ? $clog2(PORTS) : 1,
    localparam int NPIN  = PORTS * PINS,
    localparam int TW    = 3 * PINS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pin_in,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [PW-1:0]   wr_port,
    input  logic [TW-1:0]   wr_data,
    input  logic [PW-1:0]   rd_port,
    output logic [PINS-1:0] rd_status,
    output logic            irq
);

    wr_sel_e sel;
    assign sel = wr_sel_e'(wr_sel);

    logic [NPIN-1:0]  sta_all;
    logic [NPIN-1:0]  enb_all;
    logic [NPIN-1:0]  pol_all;
    logic [NPIN-1:0]  edg_all;
    logic [NPIN-1:0]  both_all;
    logic [PORTS-1:0] pend;

    for (genvar gp = 0; gp < PORTS; gp++) begin : g_port
        logic hit;
        assign hit = wr_en && (wr_port == PW'(gp));
        gpio_irq_port #(.PINS(PINS)) u_port (
            .clk     (clk),
            .rst     (rst),
            .pins    (pin_in[gp*PINS +: PINS]),
            .trig_we (hit && (sel == WR_TRIG)),
            .enb_we  (hit && (sel == WR_ENABLE)),
            .clr_we  (hit && (sel == WR_CLEAR)),
            .wdata   (wr_data),
            .sta     (sta_all[gp*PINS +: PINS]),
            .enb     (enb_all[gp*PINS +: PINS]),
            .pol     (pol_all[gp*PINS +: PINS]),
            .edg     (edg_all[gp*PINS +: PINS]),
            .both    (both_all[gp*PINS +: PINS]),
            .pend    (pend[gp])
        );
    end

    assign irq       = |pend;
    assign rd_status = sta_all[rd_port*PINS +: PINS];

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter  int PORTS = 4,
    parameter  int PINS  = 8,
    localparam int PW    = (PORTS > 1) ? $clog2(PORTS) : 1,
    localparam int NPIN  = PORTS * PINS
) (
    input logic            clk,
    input logic            rst,
    input logic            irq,
    input logic [NPIN-1:0] pin_in,
    input logic            wr_en,
    input logic [1:0]      wr_sel,
    input logic [PW-1:0]   wr_port,
    input logic [PINS-1:0] clr_data,
    input logic [NPIN-1:0] sta_all,
    input logic [NPIN-1:0] enb_all,
    input logic [NPIN-1:0] pol_all,
    input logic [NPIN-1:0] edg_all,
    input logic [NPIN-1:0] both_all
);

    logic [NPIN-1:0] clr_mask;
    logic [NPIN-1:0] pin_d1, pin_d2, pol_d1, edg_d1, both_d1;
    logic [NPIN-1:0] ev_exp, lvl_exp;

    for (genvar gp = 0; gp < PORTS; gp++) begin : g_m
        assign clr_mask[gp*PINS +: PINS] =
            (wr_en && (wr_sel_e'(wr_sel) == WR_CLEAR) && (wr_port == PW'(gp))) ? clr_data : '0;
    end

    always_ff @(posedge clk) begin
        pin_d1  <= pin_in;
        pin_d2  <= pin_d1;
        pol_d1  <= pol_all;
        edg_d1  <= edg_all;
        both_d1 <= both_all;
    end

    assign ev_exp  = edg_d1 & ((both_d1 & (pin_d1 ^ pin_d2))
                   | (~both_d1 & pol_d1 & pin_d1 & ~pin_d2)
                   | (~both_d1 & ~pol_d1 & ~pin_d1 & pin_d2));
    assign lvl_exp = ~edg_d1 & ~(pol_d1 ^ pin_d1);

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (sta_all == '0 && enb_all == '0 && !irq));

    // R7
    a_r7_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(sta_all) & ~sta_all & ~$past(clr_mask)) == '0));

    // R8
    a_r8_level_holds: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((lvl_exp & ~sta_all) == '0));

    // R9
    a_r9_edge_beats_clear: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((ev_exp & ~sta_all) == '0));

    // R10
    a_r10_irq_has_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|(sta_all & enb_all)));

    // R10
    a_r10_source_raises_irq: assert property (@(posedge clk) disable iff (rst)
        (|(sta_all & enb_all)) |-> irq);

endmodule

bind gpio_irq_bank gpio_irq_chk #(.PORTS(PORTS), .PINS(PINS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .pin_in   (pin_in),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_port  (wr_port),
    .clr_data (wr_data[PINS-1:0]),
    .sta_all  (sta_all),
    .enb_all  (enb_all),
    .pol_all  (pol_all),
    .edg_all  (edg_all),
    .both_all (both_all)
);

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;

    localparam int PORTS = 4;
    localparam int PINS  = 8;
    localparam int PW    = 2;
    localparam int NPIN  = PORTS * PINS;

    logic            clk = 1'b0;
    logic            rst;
    logic [NPIN-1:0] pin_in;
    logic            wr_en;
    logic [1:0]      wr_sel;
    logic [PW-1:0]   wr_port;
    logic [23:0]     wr_data;
    logic [PW-1:0]   rd_port;
    logic [PINS-1:0] rd_status;
    logic            irq;

    int n_chk = 0;
    int n_bad = 0;

    gpio_irq_bank #(.PORTS(PORTS), .PINS(PINS)) dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_port(wr_port), .wr_data(wr_data), .rd_port(rd_port),
        .rd_status(rd_status), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic chk_bit(input string req, input string what, input int p, input int b, input logic exp);
        rd_port = PW'(p);
        #1;
        chk(req, what, rd_status[b], exp);
    endtask

    task automatic wr(input logic [1:0] sel, input int p, input logic [23:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_port = PW'(p); wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic setpin(input int n, input logic v);
        pin_in[n] = v;
        cyc();
    endtask

    function automatic logic [23:0] code_of(input int m, input int b);
        case (m)
            0: code_of = 24'h000001 << b;
            1: code_of = 24'h000000;
            2: code_of = 24'h000101 << b;
            3: code_of = 24'h000100 << b;
            default: code_of = 24'h010100 << b;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; pin_in = '0; wr_en = 1'b0; wr_sel = '0; wr_port = '0;
        wr_data = '0; rd_port = '0;
        repeat (4) cyc();
        for (int p = 0; p < PORTS; p++) begin
            rd_port = PW'(p);
            #1;
            n_chk++;
            if (rd_status !== '0) begin
                n_bad++;
                $display("FAIL R1 reset status port %0d: got %h expected 00", p, rd_status);
            end
        end
        chk("R1", "reset irq", irq, 1'b0);
        rst = 1'b0;
        cyc();
        chk("R1", "irq after reset", irq, 1'b0);

        for (int p = 0; p < PORTS; p++) begin
            for (int b = 0; b < PINS; b++) begin
                for (int m = 0; m < 5; m++) begin
                    automatic int n = p * PINS + b;
                    automatic logic idle = (m == 1 || m == 3);
                    automatic logic act = ~idle;
                    automatic logic [23:0] mask = 24'(1) << b;
                    pin_in = idle ? '1 : '0;
                    wr(2'd0, p, code_of(m, b));
                    wr(2'd1, p, 24'h0);
                    wr(2'd2, p, 24'hFF);
                    chk_bit("R2", "idle level gives no status", p, b, 1'b0);
                    if (m <= 1) begin
                        setpin(n, act);
                        chk_bit(m == 0 ? "R2" : "R3", "active level sets", p, b, 1'b1);
                        wr(2'd2, p, mask);
                        chk_bit("R8", "clear while active ignored", p, b, 1'b1);
                        setpin(n, idle);
                        chk_bit("R8", "status held after level drops", p, b, 1'b1);
                        wr(2'd2, p, ~mask);
                        chk_bit("R7", "zero clear bit no effect", p, b, 1'b1);
                        wr(2'd2, p, mask);
                        chk_bit("R8", "clear after inactive", p, b, 1'b0);
                        setpin(n, act);
                        chk_bit("R8", "level sets again", p, b, 1'b1);
                    end else if (m <= 3) begin
                        setpin(n, act);
                        chk_bit(m == 2 ? "R4" : "R5", "edge sets", p, b, 1'b1);
                        cyc();
                        chk_bit("R7", "edge status sticky", p, b, 1'b1);
                        wr(2'd2, p, ~mask);
                        chk_bit("R7", "zero clear bit no effect", p, b, 1'b1);
                        wr(2'd2, p, mask);
                        chk_bit("R7", "clear one bit", p, b, 1'b0);
                        cyc();
                        chk_bit(m == 2 ? "R4" : "R5", "steady level no event", p, b, 1'b0);
                        setpin(n, idle);
                        chk_bit(m == 2 ? "R4" : "R5", "opposite edge ignored", p, b, 1'b0);
                        setpin(n, act);
                        chk_bit("R9", "edge after clear sets again", p, b, 1'b1);
                    end else begin
                        setpin(n, act);
                        chk_bit("R6", "rise sets", p, b, 1'b1);
                        wr(2'd2, p, mask);
                        chk_bit("R6", "cleared", p, b, 1'b0);
                        setpin(n, idle);
                        chk_bit("R6", "fall sets", p, b, 1'b1);
                        wr(2'd2, p, mask);
                        cyc();
                        chk_bit("R6", "steady no event", p, b, 1'b0);
                        setpin(n, act);
                        chk_bit("R6", "rise sets again", p, b, 1'b1);
                    end
                    chk("R10", "status without enable", irq, 1'b0);
                    wr(2'd1, p, mask);
                    chk("R10", "status with enable", irq, 1'b1);
                    wr(2'd1, p, 24'h0);
                    chk("R10", "enable removed", irq, 1'b0);
                end
            end
        end

        for (int p = 0; p < PORTS; p++) begin
            automatic int b = (2 * p + 1) % PINS;
            automatic int n = p * PINS + b;
            automatic logic [23:0] mask = 24'(1) << b;
            pin_in = '0;
            wr(2'd0, p, 24'h000101 << b);
            wr(2'd2, p, 24'hFF);
            chk_bit("R9", "setup cleared", p, b, 1'b0);
            pin_in[n] = 1'b1;
            wr(2'd2, p, mask);
            chk_bit("R9", "edge wins over same-cycle clear", p, b, 1'b1);
            wr(2'd1, p, mask);
            chk("R10", "irq from port", irq, 1'b1);
            wr(2'd2, p, mask);
            chk("R10", "irq drops after clear", irq, 1'b0);
            wr(2'd1, p, 24'h0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule